// File: doc/BRIEF.md
# ADC Offset and Gain Calibration Sequencer

This block automates the two-point calibration of an on-chip converter. It sits in front of a conversion request interface. After a start pulse it samples the converter's ground input in a burst of up to ten conversions and averages them into an offset figure. It then repeats the burst on the bandgap input to get a gain figure. At the end it raises a one-cycle done pulse and, in the same cycle, an error flag if either figure came out as zero. The voltage correction that later uses the two figures belongs to software or another block.

A conversion fails if the converter reports a failure or if no result arrives within a timeout window. The window is a cycle count set by a parameter, and its default equals 50 ms at 250 MHz. The first failed conversion ends the current burst. The average then covers only the results that arrived. The request side is a valid/ready stream. The block holds `req_valid` and keeps `req_sel` steady until the converter accepts with `req_ready`. After acceptance the block raises `res_ready` and waits for exactly one `res_valid` or `res_fail`. It has no result buffer, so back-pressure reaches the converter only through `req_ready`. Results offered while `res_ready` is low are not taken.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, `done`, `err`, `req_valid` and `res_ready` are low, and `offset_avg` and `gain_avg` are zero.
- R2: The offset phase runs first and requests only select code 0xB (ground). The gain phase follows and requests only select code 0xC (bandgap). While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_sel` does not change.
- R3: Each phase issues at most 10 requests. When all succeed, it sums the ten 14-bit results in an 18-bit accumulator.
- R4: A failed conversion (`res_fail` high while waiting) ends the phase with no further requests. The phase result is the floor of the sum of the successful results divided by their count.
- R5: A phase with no successful results gives a result of zero.
- R6: A zero offset result ends the sequence with `err` high. The gain phase is skipped entirely and `gain_avg` stays zero.
- R7: A zero gain result ends the sequence with `err` high.
- R8: If no result arrives within TIMEOUT_CYC cycles after a request is accepted, the conversion counts as failed. With the gain phase's first request timing out, `done` rises TIMEOUT_CYC+3 cycles after the cycle in which `req_ready` was first driven high.
- R9: `done` is high for exactly one cycle per sequence. `err` is high only together with `done`, and it is low when both results are nonzero.
- R10: A start pulse during a running sequence is ignored. It causes no restart and no extra done pulse.
- R11: `offset_avg` and `gain_avg` are cleared when a sequence starts. They show their results from `done` onward and hold them until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a calibration sequence when idle |
| req_valid | output | 1 | Conversion request is pending |
| req_ready | input | 1 | Converter accepts the pending request |
| req_sel | output | 4 | Input select code for the request |
| res_valid | input | 1 | Conversion result is present |
| res_ready | output | 1 | Block is waiting for a result |
| res_data | input | 14 | Conversion result |
| res_fail | input | 1 | Converter reports a failed conversion |
| offset_avg | output | 14 | Averaged ground reading |
| gain_avg | output | 14 | Averaged bandgap reading |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Calibration failed, valid with done |

## Verification
Directed sequences cover four situations. A full burst with distinct values checks the plain sum and divide. A burst cut short by a reported failure checks that the divisor is the success count and that the quotient is a floor. A zero-result phase, caused either by an immediate failure or by all-zero readings, checks the error path and that the gain phase is skipped. A first gain request that gets no result at all checks the timeout and its exact latency. Seeded random scripts mix accept delays, result delays, failures and timeouts at random positions. These show that the request count, the select order and both averages follow the success count in every combination. One sequence also carries an extra start pulse partway through, to show that it has no effect.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_DIV_GO,
    S_DIV_WAIT,
    S_END,
    S_DONE
  } cal_state_t;

  typedef enum logic {
    PH_OFFSET,
    PH_GAIN
  } cal_phase_t;
endpackage

// File: rtl/cal_accum.sv
module cal_accum #(
  parameter int DATA_W = 14,
  parameter int BURST  = 10,
  parameter int CNT_W  = $clog2(BURST + 1),
  parameter int ACC_W  = DATA_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  output logic [ACC_W-1:0]  sum,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [ACC_W-1:0] MAXV = ACC_W'((1 << DATA_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum <= '0;
      cnt <= '0;
    end else if (clr) begin
      sum <= '0;
      cnt <= '0;
    end else if (add) begin
      sum <= sum + ACC_W'(din);
      cnt <= cnt + 1'b1;
    end
  end

  // R3: never more than one burst of successes
  p_cnt_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BURST));
  // R3: sum bounded by count times the largest sample
  p_sum_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sum <= ACC_W'(cnt) * MAXV);
endmodule

// File: rtl/cal_watch.sv
module cal_watch #(
  parameter int LIMIT = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [TW-1:0] tick;

  assign expired = run && (tick == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        tick <= '0;
    else if (!run)     tick <= '0;
    else if (!expired) tick <= tick + 1'b1;
  end

  // R8: an expiry ends the wait, so it never lasts two cycles
  p_expire_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);
endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int SW = $clog2(NUM_W + 1);
  localparam int EW = NUM_W + DEN_W;

  logic [NUM_W-1:0] num_hold;
  logic [DEN_W-1:0] den_hold;
  logic [DEN_W-1:0] rem;
  logic [SW-1:0]    steps;
  logic             busy;
  logic [DEN_W:0]   trial;

  assign trial = {rem, quo[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo <= '0; rem <= '0; steps <= '0; busy <= 1'b0; done <= 1'b0;
      num_hold <= '0; den_hold <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo <= num; num_hold <= num; den_hold <= den;
        rem <= '0; steps <= SW'(NUM_W); busy <= 1'b1;
      end else if (busy) begin
        if (trial >= {1'b0, den_hold}) begin
          rem <= DEN_W'(trial - {1'b0, den_hold});
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        steps <= steps - 1'b1;
        if (steps == SW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4: quotient and remainder reconstruct the dividend
  p_div_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (EW'(quo) * EW'(den_hold) + EW'(rem)) == EW'(num_hold));
  // R4: floor division leaves a remainder below the divisor
  p_rem_lt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rem < den_hold);
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_pkg::*;
#(
  parameter int             DATA_W      = 14,
  parameter int             SEL_W       = 4,
  parameter int             BURST       = 10,
  parameter logic [SEL_W-1:0] OFS_SEL   = 4'hB,
  parameter logic [SEL_W-1:0] GAIN_SEL  = 4'hC,
  parameter int             TIMEOUT_CYC = 12_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [SEL_W-1:0]  req_sel,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_fail,
  output logic [DATA_W-1:0] offset_avg,
  output logic [DATA_W-1:0] gain_avg,
  output logic              done,
  output logic              err
);
  localparam int CNT_W = $clog2(BURST + 1);
  localparam int ACC_W = DATA_W + CNT_W;

  cal_state_t        state;
  cal_phase_t        phase;
  logic [DATA_W-1:0] res_q;
  logic              err_r;
  logic [ACC_W-1:0]  acc_sum;
  logic [CNT_W-1:0]  acc_cnt;
  logic              acc_clr, acc_add;
  logic              expired;
  logic              div_start, div_done;
  logic [ACC_W-1:0]  div_q;

  assign req_valid = (state == S_ISSUE);
  assign req_sel   = (phase == PH_GAIN) ? GAIN_SEL : OFS_SEL;
  assign res_ready = (state == S_WAIT);
  assign done      = (state == S_DONE);
  assign err       = done && err_r;

  assign acc_clr   = (state == S_IDLE && start) ||
                     (state == S_END && phase == PH_OFFSET && res_q != '0);
  assign acc_add   = (state == S_WAIT) && res_valid && !res_fail;
  assign div_start = (state == S_DIV_GO) && (acc_cnt != '0);

  cal_accum #(.DATA_W(DATA_W), .BURST(BURST), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add), .din(res_data),
    .sum(acc_sum), .cnt(acc_cnt)
  );

  cal_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .run(state == S_WAIT), .expired(expired)
  );

  cal_divider #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(acc_sum), .den(acc_cnt),
    .done(div_done), .quo(div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      phase      <= PH_OFFSET;
      res_q      <= '0;
      err_r      <= 1'b0;
      offset_avg <= '0;
      gain_avg   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state      <= S_ISSUE;
          phase      <= PH_OFFSET;
          offset_avg <= '0;
          gain_avg   <= '0;
          err_r      <= 1'b0;
        end
        S_ISSUE: if (req_ready) state <= S_WAIT;
        S_WAIT: begin
          if (res_fail) state <= S_DIV_GO;
          else if (res_valid)
            state <= (acc_cnt == CNT_W'(BURST - 1)) ? S_DIV_GO : S_ISSUE;
          else if (expired) state <= S_DIV_GO;
        end
        S_DIV_GO: begin
          if (acc_cnt == '0) begin
            res_q <= '0;
            state <= S_END;
          end else begin
            state <= S_DIV_WAIT;
          end
        end
        S_DIV_WAIT: if (div_done) begin
          res_q <= div_q[DATA_W-1:0];
          state <= S_END;
        end
        S_END: begin
          if (phase == PH_OFFSET) begin
            offset_avg <= res_q;
            if (res_q == '0) begin
              err_r <= 1'b1;
              state <= S_DONE;
            end else begin
              phase <= PH_GAIN;
              state <= S_ISSUE;
            end
          end else begin
            gain_avg <= res_q;
            err_r    <= (res_q == '0);
            state    <= S_DONE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a pending request is held steady until accepted
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_sel)));
  // R2: only the two reference codes are ever requested
  p_sel_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_sel == OFS_SEL || req_sel == GAIN_SEL));
  // R4: the average always fits the sample width
  p_quo_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (div_q >> DATA_W) == '0);
  // R6: a zero offset at the end is always an error
  p_zero_ofs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && offset_avg == '0) |-> err);
  // R7: a clean finish has two nonzero averages
  p_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (offset_avg != '0 && gain_avg != '0));
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: error only appears with done
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R11: results hold while idle without a start
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> ($stable(offset_avg) && $stable(gain_avg)));
endmodule

// File: tb/cal_sequencer_bench.sv
module cal_sequencer_bench;
  localparam int TMO = 40;
  localparam int A_OK = 0, A_FAIL = 1, A_TMO = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid, req_ready = 1'b0;
  logic [3:0]  req_sel;
  logic        res_valid = 1'b0, res_ready, res_fail = 1'b0;
  logic [13:0] res_data = '0;
  logic [13:0] offset_avg, gain_avg;
  logic        done, err;

  always #2 clk = ~clk;

  cal_sequencer #(.TIMEOUT_CYC(TMO)) u_cal_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_fail(res_fail), .offset_avg(offset_avg), .gain_avg(gain_avg),
    .done(done), .err(err)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int act [0:19];
  int val [0:19];
  int dly [0:19];
  logic [3:0] sel_log [0:1023];
  int req_total = 0, hs_cyc = 0, script_base = 0;
  int done_cnt = 0, done_cyc = 0;
  logic done_err = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (done) begin
    done_cnt <= done_cnt + 1;
    done_cyc <= cyc;
    done_err <= err;
  end

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      req_ready = 1'b0; res_valid = 1'b0; res_fail = 1'b0;
      if (req_valid) begin
        int k;
        repeat ($urandom % 3) @(negedge clk);
        k = req_total - script_base;
        if (k > 19) k = 19;
        sel_log[req_total % 1024] = req_sel;
        hs_cyc = cyc;
        req_ready = 1'b1;
        req_total++;
        @(negedge clk);
        req_ready = 1'b0;
        if (act[k] == A_OK) begin
          repeat (dly[k]) @(negedge clk);
          res_data = val[k][13:0];
          res_valid = 1'b1;
          @(negedge clk);
          res_valid = 1'b0;
        end else if (act[k] == A_FAIL) begin
          repeat (dly[k]) @(negedge clk);
          res_fail = 1'b1;
          @(negedge clk);
          res_fail = 1'b0;
        end
      end
    end
  end

  task automatic model(output int e_off, output int e_gain, output int e_err,
                       output int e_nreq, output int e_nofs);
    int k = 0;
    int s, c;
    s = 0; c = 0;
    for (int i = 0; i < 10; i++) begin
      k++;
      if (act[k-1] != A_OK) break;
      s += val[k-1]; c++;
    end
    e_nofs = k;
    e_off = (c == 0) ? 0 : s / c;
    e_gain = 0;
    if (e_off == 0) begin
      e_err = 1; e_nreq = k; return;
    end
    s = 0; c = 0;
    for (int i = 0; i < 10; i++) begin
      k++;
      if (act[k-1] != A_OK) break;
      s += val[k-1]; c++;
    end
    e_gain = (c == 0) ? 0 : s / c;
    e_err = (e_gain == 0) ? 1 : 0;
    e_nreq = k;
  endtask

  task automatic run_case(input string name, input bit extra_start, input bit time_gap);
    int e_off, e_gain, e_err, e_nreq, e_nofs, d0, base, w;
    logic [13:0] h_off, h_gain;
    model(e_off, e_gain, e_err, e_nreq, e_nofs);
    base = req_total;
    script_base = req_total;
    d0 = done_cnt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(offset_avg == 0 && gain_avg == 0, {"R11 clear at start ", name}, offset_avg, 0);
    if (extra_start) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done_cnt == d0 && w < 4000) begin
      @(negedge clk); w++;
    end
    if (done_cnt == d0) begin
      chk(1'b0, {"watchdog ", name}, 0, 1);
      return;
    end
    chk(err == 1'b0 && done == 1'b0, {"R9 done one cycle ", name}, done, 0);
    chk(done_err == e_err[0], {"R6 R7 R9 err ", name}, done_err, e_err);
    chk(offset_avg == e_off[13:0], {"R3 R4 R5 offset ", name}, offset_avg, e_off);
    chk(gain_avg == e_gain[13:0], {"R3 R4 R5 gain ", name}, gain_avg, e_gain);
    chk(req_total - base == e_nreq, {"R3 R4 R6 R10 request count ", name}, req_total - base, e_nreq);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < e_nreq; i++)
        if (sel_log[(base + i) % 1024] != ((i < e_nofs) ? 4'hB : 4'hC)) ok = 1'b0;
      chk(ok, {"R2 select order ", name}, ok, 1);
    end
    if (time_gap)
      chk(done_cyc - hs_cyc == TMO + 3, {"R8 timeout latency ", name}, done_cyc - hs_cyc, TMO + 3);
    h_off = offset_avg; h_gain = gain_avg;
    repeat (8) @(negedge clk);
    chk(offset_avg == h_off && gain_avg == h_gain && done_cnt == d0 + 1,
        {"R10 R11 hold after done ", name}, done_cnt - d0, 1);
  endtask

  task automatic fill(input int a, input int v, input int d);
    for (int i = 0; i < 20; i++) begin act[i] = a; val[i] = v; dly[i] = d; end
  endtask

  initial begin
    void'($urandom(32'd1357));
    fill(A_OK, 0, 0);
    repeat (3) @(negedge clk);
    chk(done == 0 && err == 0 && req_valid == 0 && res_ready == 0, "R1 reset controls", done, 0);
    chk(offset_avg == 0 && gain_avg == 0, "R1 reset outputs", offset_avg, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_valid == 0 && done == 0, "R1 idle after reset", req_valid, 0);

    // full bursts, distinct values
    for (int i = 0; i < 20; i++) begin
      act[i] = A_OK; val[i] = (i < 10) ? 100 + i : 8000 + 3 * i; dly[i] = i % 4;
    end
    run_case("full", 1'b0, 1'b0);

    // all-zero offset
    fill(A_OK, 0, 1);
    run_case("zero offset", 1'b0, 1'b0);

    // immediate failure in offset phase
    fill(A_OK, 500, 1); act[0] = A_FAIL;
    run_case("first fail", 1'b0, 1'b0);

    // short offset burst with floor division
    fill(A_OK, 7000, 2);
    val[0] = 5; val[1] = 6; val[2] = 6; act[3] = A_FAIL;
    run_case("short burst", 1'b0, 1'b0);

    // gain first request times out
    fill(A_OK, 321, 0); act[10] = A_TMO;
    run_case("gain timeout", 1'b0, 1'b1);

    // offset times out mid-burst, extra start while busy
    fill(A_OK, 900, 3);
    for (int i = 0; i < 6; i++) val[i] = 40 + 7 * i;
    act[6] = A_TMO;
    run_case("ofs timeout extra start", 1'b1, 1'b0);

    // all-zero gain
    fill(A_OK, 0, 1);
    for (int i = 0; i < 10; i++) val[i] = 16383;
    run_case("zero gain", 1'b0, 1'b0);

    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 20; i++) begin
        int p = $urandom % 100;
        act[i] = (p < 88) ? A_OK : (p < 94) ? A_FAIL : A_TMO;
        val[i] = ($urandom % 20 == 0) ? 0 : $urandom % 16384;
        dly[i] = $urandom % 12;
      end
      run_case($sformatf("random %0d", r), r == 3, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4 - 40);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule